// File: doc/BRIEF.md
# TLB Control and Way-Replacement Register

This block is the software-visible control register of a set-associative translation buffer with four ways per set. It stores three things: a bit that places the memory system in single-address-space operation, a bit that chooses how the set index is formed, and a small replacement counter. The counter names the way that the next refill will overwrite. Writing a one to the flush position of the register raises a pulse, in the same cycle, that clears every valid bit in the translation buffer. The buffer array itself lies outside this block.

Hardware updates the replacement counter whenever the memory unit raises an exception. The rule depends on the kind of exception:
- On a miss, the counter takes the first free way of the addressed set.
- If that set is full, the counter advances by one instead.
- On any other exception, the counter takes the way that caused it.

The block also forms the five-bit set index. The index is either the low virtual page number bits alone or those bits mixed with the address-space identifier, depending on the index-mode bit.

Top module: `tlb_ctl_reg`

## Requirements
- R1: After reset every stored field is 0, so `rd_data` reads 0x0000_0000 and `refill_way` is 0.
- R2: A cycle with `wr_en` high stores `wr_data` bit 0 as the single-space mode bit, bit 1 as the index-hash mode bit and bits 9:8 as the replacement counter. `rd_data` returns them at the same positions, combinationally, from the following cycle on.
- R3: A `miss_pulse` cycle with all four `set_valid` bits high increments the counter by one modulo 4.
- R4: A `miss_pulse` cycle with at least one `set_valid` bit low loads the counter with the lowest-numbered way whose valid bit is low.
- R5: An `exc_pulse` cycle without `miss_pulse` loads the counter with `exc_way`. When both pulses are high, the miss rule applies.
- R6: `flush_pulse` is high exactly in a cycle where `wr_en` is high and `wr_data` bit 2 is 1. Bit 2 of `rd_data` always reads 0.
- R7: With the index-hash mode bit at 0, `set_idx` equals `vpn_idx`. With it at 1, `set_idx` equals `vpn_idx` XOR `asid_idx`.
- R8: Every `rd_data` bit other than 0, 1, 8 and 9 reads 0, whatever was written.
- R9: When a write and a hardware counter update fall in the same cycle, the counter takes the hardware value. The two mode bits still take the written values.
- R10: `refill_way` always equals the stored counter (`rd_data` bits 9:8).
- R11: In a cycle with no write, no miss and no other exception, the register contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational register read data |
| miss_pulse | input | 1 | One-cycle translation miss indication |
| exc_pulse | input | 1 | One-cycle indication of any other memory-unit exception |
| exc_way | input | 2 | Way that caused the non-miss exception |
| set_valid | input | 4 | Valid bits of the four ways of the set addressed on a miss |
| vpn_idx | input | 5 | Virtual page number bits 16 to 12 |
| asid_idx | input | 5 | Low five bits of the current address-space identifier |
| single_space | output | 1 | Single-address-space mode bit |
| idx_hash | output | 1 | Index-hash mode bit |
| flush_pulse | output | 1 | One-cycle strobe clearing all translation-buffer valid bits |
| set_idx | output | 5 | Set index presented to the translation buffer |
| refill_way | output | 2 | Way selected for the next refill |

## Verification
The bench drives misses with valid patterns whose free ways sit in different positions, including one where only the top way is free and one where no way is free. A priority encoder built the wrong way round would pick a higher free way, and a missing full-set test would reload way 0 instead of advancing the counter. It also steps the counter across the 3-to-0 wrap, raises a miss and an exception in the same cycle, and collides a write with a hardware update. A design with the wrong priority would let the exception way or the written count survive. Finally it writes all ones to confirm that reserved bits and the flush bit read back 0, and it checks the set index under both index modes.

// File: rtl/tlb_ctl_pkg.sv
package tlb_ctl_pkg;
   // Register width and field placement
   localparam int unsigned REG_W     = 32;
   localparam int unsigned SPACE_BIT = 0;
   localparam int unsigned HASH_BIT  = 1;
   localparam int unsigned FLUSH_BIT = 2;
   localparam int unsigned CTR_LSB   = 8;

   // Kind of hardware update applied to the replacement counter
   typedef enum logic [1:0] {
      UPD_NONE  = 2'd0,
      UPD_ADV   = 2'd1,
      UPD_FREE  = 2'd2,
      UPD_FAULT = 2'd3
   } upd_kind_e;

   // Mask of defined (readable) bits for a given counter width
   function automatic logic [REG_W-1:0] live_mask(input int unsigned ctr_w);
      logic [REG_W-1:0] m;
      m = '0;
      m[SPACE_BIT] = 1'b1;
      m[HASH_BIT]  = 1'b1;
      for (int unsigned i = 0; i < ctr_w; i++) m[CTR_LSB + i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
   import tlb_ctl_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 4,
   localparam int unsigned WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
   input  logic [WAY_W-1:0]    ctr_q,
   input  logic                miss_pulse,
   input  logic                exc_pulse,
   input  logic [WAY_W-1:0]    exc_way,
   input  logic [NUM_WAYS-1:0] set_valid,
   output logic                upd_en,
   output logic [WAY_W-1:0]    upd_val,
   output upd_kind_e           upd_kind
);
   // Per-way "first free" flags built with a generate chain
   logic [NUM_WAYS-1:0] free_seen;
   logic [NUM_WAYS-1:0] first_free;

   genvar gw;
   generate
      for (gw = 0; gw < NUM_WAYS; gw++) begin : g_chain
         if (gw == 0) begin : g_head
            assign first_free[gw] = ~set_valid[gw];
            assign free_seen[gw]  = ~set_valid[gw];
         end else begin : g_link
            assign first_free[gw] = ~set_valid[gw] & ~free_seen[gw-1];
            assign free_seen[gw]  = ~set_valid[gw] | free_seen[gw-1];
         end
      end
   endgenerate

   // Encode the one-hot first-free vector
   logic [WAY_W-1:0] free_way;
   always_comb begin
      free_way = '0;
      for (int unsigned w = 0; w < NUM_WAYS; w++) begin
         if (first_free[w]) free_way = free_way | WAY_W'(w);
      end
   end

   logic             set_full;
   logic [WAY_W-1:0] ctr_next;
   assign set_full = &set_valid;
   assign ctr_next = ctr_q + WAY_W'(1);

   always_comb begin
      upd_kind = UPD_NONE;
      if (miss_pulse)     upd_kind = set_full ? UPD_ADV : UPD_FREE;
      else if (exc_pulse) upd_kind = UPD_FAULT;
   end

   always_comb begin
      unique case (upd_kind)
         UPD_ADV:   upd_val = ctr_next;
         UPD_FREE:  upd_val = free_way;
         UPD_FAULT: upd_val = exc_way;
         default:   upd_val = ctr_q;
      endcase
   end

   assign upd_en = (upd_kind != UPD_NONE);
endmodule

// File: rtl/tlb_set_hash.sv
module tlb_set_hash #(
   parameter int unsigned IDX_W       = 5,
   parameter bit          HASH_SUPPORT = 1'b1
) (
   input  logic             hash_on,
   input  logic [IDX_W-1:0] vpn_idx,
   input  logic [IDX_W-1:0] asid_idx,
   output logic [IDX_W-1:0] set_idx
);
   generate
      if (HASH_SUPPORT) begin : g_hashed
         logic [IDX_W-1:0] mixed;
         assign mixed   = vpn_idx ^ asid_idx;
         assign set_idx = hash_on ? mixed : vpn_idx;
      end else begin : g_plain
         logic unused_hash;
         assign unused_hash = hash_on ^ (^asid_idx);
         assign set_idx     = vpn_idx;
      end
   endgenerate
endmodule

// File: rtl/tlb_ctl_fields.sv
module tlb_ctl_fields
   import tlb_ctl_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 4,
   localparam int unsigned WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             upd_en,
   input  logic [WAY_W-1:0] upd_val,
   output logic             space_q,
   output logic             hash_q,
   output logic [WAY_W-1:0] ctr_q,
   output logic             flush_pulse,
   output logic [REG_W-1:0] rd_data
);
   localparam logic [REG_W-1:0] LIVE = live_mask(WAY_W);

   // Mode bits: software only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         space_q <= 1'b0;
         hash_q  <= 1'b0;
      end else if (wr_en) begin
         space_q <= wr_data[SPACE_BIT];
         hash_q  <= wr_data[HASH_BIT];
      end
   end

   // Counter: hardware update outranks a software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctr_q <= '0;
      else if (upd_en) ctr_q <= upd_val;
      else if (wr_en)  ctr_q <= wr_data[CTR_LSB +: WAY_W];
   end

   // Flush is never stored; it is a strobe on the write cycle
   assign flush_pulse = wr_en & wr_data[FLUSH_BIT];

   always_comb begin
      rd_data = '0;
      rd_data[SPACE_BIT]          = space_q;
      rd_data[HASH_BIT]           = hash_q;
      rd_data[CTR_LSB +: WAY_W]   = ctr_q;
      rd_data                     = rd_data & LIVE;
   end

   logic unused_wdata;
   assign unused_wdata = ^(wr_data & ~LIVE & ~(REG_W'(1) << FLUSH_BIT));
endmodule

// File: rtl/tlb_ctl_reg.sv
module tlb_ctl_reg
   import tlb_ctl_pkg::*;
#(
   parameter int unsigned NUM_WAYS     = 4,
   parameter int unsigned IDX_W        = 5,
   parameter bit          HASH_SUPPORT = 1'b1,
   localparam int unsigned WAY_W       = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data,
   input  logic                miss_pulse,
   input  logic                exc_pulse,
   input  logic [WAY_W-1:0]    exc_way,
   input  logic [NUM_WAYS-1:0] set_valid,
   input  logic [IDX_W-1:0]    vpn_idx,
   input  logic [IDX_W-1:0]    asid_idx,
   output logic                single_space,
   output logic                idx_hash,
   output logic                flush_pulse,
   output logic [IDX_W-1:0]    set_idx,
   output logic [WAY_W-1:0]    refill_way
);
   // Elaboration-time parameter checks
   generate
      if (NUM_WAYS < 2 || NUM_WAYS != (1 << WAY_W)) begin : g_bad_ways
         $error("NUM_WAYS must be a power of two of at least 2");
      end
      if (CTR_LSB + WAY_W > REG_W) begin : g_bad_ctr
         $error("counter field does not fit the register");
      end
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("IDX_W out of range");
      end
   endgenerate

   logic             upd_en;
   logic [WAY_W-1:0] upd_val;
   logic [WAY_W-1:0] ctr_q;
   upd_kind_e        upd_kind;

   tlb_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_victim (
      .ctr_q      (ctr_q),
      .miss_pulse (miss_pulse),
      .exc_pulse  (exc_pulse),
      .exc_way    (exc_way),
      .set_valid  (set_valid),
      .upd_en     (upd_en),
      .upd_val    (upd_val),
      .upd_kind   (upd_kind)
   );

   tlb_ctl_fields #(.NUM_WAYS(NUM_WAYS)) u_fields (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .upd_en      (upd_en),
      .upd_val     (upd_val),
      .space_q     (single_space),
      .hash_q      (idx_hash),
      .ctr_q       (ctr_q),
      .flush_pulse (flush_pulse),
      .rd_data     (rd_data)
   );

   tlb_set_hash #(.IDX_W(IDX_W), .HASH_SUPPORT(HASH_SUPPORT)) u_hash (
      .hash_on  (idx_hash),
      .vpn_idx  (vpn_idx),
      .asid_idx (asid_idx),
      .set_idx  (set_idx)
   );

   assign refill_way = ctr_q;

   logic unused_kind;
   assign unused_kind = ^upd_kind;
endmodule

// File: rtl/tlb_ctl_reg_chk.sv
module tlb_ctl_reg_chk
   import tlb_ctl_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 4,
   parameter int unsigned IDX_W    = 5,
   localparam int unsigned WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [REG_W-1:0]    rd_data,
   input logic                miss_pulse,
   input logic                exc_pulse,
   input logic [WAY_W-1:0]    exc_way,
   input logic [NUM_WAYS-1:0] set_valid,
   input logic [IDX_W-1:0]    vpn_idx,
   input logic [IDX_W-1:0]    set_idx,
   input logic [WAY_W-1:0]    refill_way
);
   localparam logic [REG_W-1:0] LIVE = live_mask(WAY_W);

   logic [WAY_W-1:0]    ctr_v;
   logic [WAY_W-1:0]    ctr_inc;
   logic [NUM_WAYS-1:0] valid_d;
   assign ctr_v   = rd_data[CTR_LSB +: WAY_W];
   assign ctr_inc = ctr_v + WAY_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_d <= '1;
      else        valid_d <= set_valid;
   end

   // R3 (also R9: holds whether or not a write collides)
   assert_full_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_pulse && (&set_valid)) |=> (ctr_v == $past(ctr_inc)));

   // R4: chosen way was free in the sampled set
   assert_free_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_pulse && !(&set_valid)) |=> (valid_d[ctr_v] == 1'b0));

   // R5 (also R9)
   assert_fault_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_pulse && !miss_pulse) |=> (ctr_v == $past(exc_way)));

   assert_flush_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[FLUSH_BIT] == 1'b0);

   assert_plain_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[HASH_BIT] |-> (set_idx == vpn_idx));

   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~LIVE) == '0);

   assert_refill_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
      refill_way == ctr_v);

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !miss_pulse && !exc_pulse) |=> $stable(rd_data));
endmodule

bind tlb_ctl_reg tlb_ctl_reg_chk #(.NUM_WAYS(NUM_WAYS), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_data    (rd_data),
   .miss_pulse (miss_pulse),
   .exc_pulse  (exc_pulse),
   .exc_way    (exc_way),
   .set_valid  (set_valid),
   .vpn_idx    (vpn_idx),
   .set_idx    (set_idx),
   .refill_way (refill_way)
);

// File: tb/tb_tlb_ctl_reg.sv
`timescale 1ns/1ps
module tb_tlb_ctl_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        miss_pulse = 1'b0;
   logic        exc_pulse = 1'b0;
   logic [1:0]  exc_way = '0;
   logic [3:0]  set_valid = '0;
   logic [4:0]  vpn_idx = '0;
   logic [4:0]  asid_idx = '0;
   logic        single_space, idx_hash, flush_pulse;
   logic [4:0]  set_idx;
   logic [1:0]  refill_way;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   tlb_ctl_reg dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .miss_pulse(miss_pulse), .exc_pulse(exc_pulse), .exc_way(exc_way),
      .set_valid(set_valid), .vpn_idx(vpn_idx), .asid_idx(asid_idx),
      .single_space(single_space), .idx_hash(idx_hash), .flush_pulse(flush_pulse),
      .set_idx(set_idx), .refill_way(refill_way)
   );

   typedef struct {
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t sb[$];

   // Reference model state
   logic       m_space = 1'b0;
   logic       m_hash  = 1'b0;
   logic [1:0] m_ctr   = 2'd0;

   function automatic logic [31:0] model_rd();
      return {22'd0, m_ctr, 6'd0, m_hash, m_space};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the expected read-back
   task automatic step(input logic we, input logic [31:0] wd, input logic ms,
                       input logic ex, input logic [1:0] ew, input logic [3:0] vld,
                       input logic [4:0] v, input logic [4:0] a, input string req);
      logic [1:0] nctr;
      @(negedge clk);
      wr_en = we; wr_data = wd; miss_pulse = ms; exc_pulse = ex;
      exc_way = ew; set_valid = vld; vpn_idx = v; asid_idx = a;
      #1;
      check("R6 flush strobe", {31'd0, flush_pulse}, {31'd0, we & wd[2]});
      check("R7 set index", {27'd0, set_idx}, {27'd0, m_hash ? (v ^ a) : v});
      check("R10 refill way", {30'd0, refill_way}, {30'd0, m_ctr});
      nctr = m_ctr;
      if (ms) begin
         if (&vld) nctr = m_ctr + 2'd1;
         else if (!vld[0]) nctr = 2'd0;
         else if (!vld[1]) nctr = 2'd1;
         else if (!vld[2]) nctr = 2'd2;
         else nctr = 2'd3;
      end else if (ex) nctr = ew;
      else if (we) nctr = wd[9:8];
      if (we) begin
         m_space = wd[0];
         m_hash  = wd[1];
      end
      m_ctr = nctr;
      sb.push_back('{exp: model_rd(), req: req});
   endtask

   task automatic idle_inputs();
      @(negedge clk);
      wr_en = 1'b0; miss_pulse = 1'b0; exc_pulse = 1'b0;
   endtask

   // Monitor: compares the register after each edge with the queued value
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.req, rd_data, it.exp);
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset read", rd_data, 32'h0);
      check("R1 reset refill", {30'd0, refill_way}, 32'h0);

      // R2 write and read back
      step(1, 32'h0000_0103, 0, 0, 0, 4'hF, 5'h0A, 5'h03, "R2 write fields");
      step(1, 32'h0000_0000, 0, 0, 0, 4'hF, 5'h0A, 5'h03, "R2 clear fields");
      // R8 all-ones write: reserved bits ignored, flush bit reads 0
      step(1, 32'hFFFF_FFFF, 0, 0, 0, 4'hF, 5'h15, 5'h0F, "R8 reserved ignored");
      // R7 hashed index patterns (hash bit now 1)
      step(0, 0, 0, 0, 0, 4'hF, 5'h1F, 5'h1F, "R11 idle hold");
      step(0, 0, 0, 0, 0, 4'hF, 5'h10, 5'h01, "R7 hashed idle");
      // R6 flush-only write; clears mode bits and counter
      step(1, 32'h0000_0004, 0, 0, 0, 4'hF, 5'h04, 5'h1C, "R6 flush write");
      step(0, 0, 0, 0, 0, 4'hF, 5'h07, 5'h18, "R11 idle after flush");
      // R3 full set: advance across the wrap
      for (int i = 0; i < 5; i++)
         step(0, 0, 1, 0, 0, 4'hF, 5'h02, 5'h00, "R3 full advance");
      // R4 lowest free way
      step(0, 0, 1, 0, 0, 4'b1110, 5'h00, 5'h00, "R4 free way0");
      step(0, 0, 1, 0, 0, 4'b0101, 5'h00, 5'h00, "R4 free way1");
      step(0, 0, 1, 0, 0, 4'b0011, 5'h00, 5'h00, "R4 free way2");
      step(0, 0, 1, 0, 0, 4'b0111, 5'h00, 5'h00, "R4 free way3");
      step(0, 0, 1, 0, 0, 4'b0000, 5'h00, 5'h00, "R4 all free");
      // R5 other exception loads faulting way; miss wins a tie
      step(0, 0, 0, 1, 2'd2, 4'hF, 5'h00, 5'h00, "R5 fault way2");
      step(0, 0, 0, 1, 2'd1, 4'h0, 5'h00, 5'h00, "R5 fault way1");
      step(0, 0, 1, 1, 2'd0, 4'hF, 5'h00, 5'h00, "R5 miss beats fault");
      // R9 write collides with hardware update
      step(1, 32'h0000_0203, 1, 0, 0, 4'hF, 5'h09, 5'h06, "R9 hw beats write");
      step(1, 32'h0000_0100, 0, 1, 2'd3, 4'hF, 5'h09, 5'h06, "R9 fault beats write");
      step(0, 0, 0, 0, 0, 4'hF, 5'h11, 5'h06, "R11 idle hold end");
      idle_inputs();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule